// File: doc/BRIEF.md
# Indexed Clock Register Port

The block gives a host a two-location window onto a 128-byte space of clock and configuration bytes. The host writes a byte to the even location to select an entry. It then reads or writes the odd location to reach that entry. Most entries are plain storage. Four entries (indices 10 to 13) hold the status and control state that a calendar engine and a periodic tick generator use. Those four entries have their own write masking, read-only bits and clear-on-read behaviour.

The calendar and tick blocks sit outside this one. They reach it through side-band pins. They can mark an update as in progress, end that mark, and raise pending interrupt flags. In return they see control bytes A and B directly, plus a strobe that asks them to reload the running time from the stored time bytes. The interrupt output is high while any flag is pending. Reading status byte C returns its contents and empties it in the same access.

Top module: `rtc_index_port`

## Requirements
- R1: A write to the even location (addr_i=0) loads the 7-bit index with wdata_i[6:0]; bit 7 is dropped, so writing 0x8B selects index 11.
- R2: A read of the even location returns 0xFF.
- R3: Control byte A (index 10) bit 7 is the update-in-progress flag and is read-only to the host: a host write changes only bits 6:0.
- R4: Writing control byte B (index 11) with bit 7 (freeze) set stores bit 4 as 0 whatever was written, and clears byte A bit 7.
- R5: Host writes to status byte C (index 12) and to byte D (index 13) have no effect; D always reads 0x80.
- R6: Reading byte C returns {any flag, periodic, alarm, update-ended, 0000} (bits 7,6,5,4), then clears all flags; irq_o falls in the next cycle.
- R7: After reset, bytes A, B, C and D read 0x26, 0x02, 0x00 and 0x80, and irq_o is low.
- R8: All other indices, the alarm bytes 1, 3 and 5 among them, store the written byte and read it back unchanged.
- R9: time_reload_o is high during an odd-location write to a time index (0, 2, 4, 6, 7, 8, 9) while B bit 7 is 0. It is also high during a write to B with bit 7 = 0 while the stored B bit 7 is 1. It is low during every other write.
- R10: A flag raised through flag_set_i (bit 2 periodic, bit 1 alarm, bit 0 update-ended) in the same cycle as a read of C survives the clear, and irq_o stays high.
- R11: irq_o is high exactly while at least one flag is pending.
- R12: uip_set_i sets byte A bit 7 only while B bit 7 is 0; uip_clr_i clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 1 | 0 = index location, 1 = data location |
| wdata_i | input | 8 | Host write data |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| rdata_o | output | 8 | Read data, valid in the cycle rd_i is high |
| irq_o | output | 1 | Interrupt, high while any flag is pending |
| uip_set_i | input | 1 | Calendar: update started |
| uip_clr_i | input | 1 | Calendar: update finished |
| flag_set_i | input | 3 | Raise flags: [2] periodic, [1] alarm, [0] update-ended |
| ctrl_a_o | output | 8 | Current control byte A |
| ctrl_b_o | output | 8 | Current control byte B |
| time_reload_o | output | 1 | Request to reload the running time from stored bytes |

## Verification
The assertions assume that wr_i and rd_i are never high together. They also assume that uip_set_i and uip_clr_i are never asserted in the same cycle, because the properties on byte A bit 7 give no meaning to a host write that coincides with a calendar update. The stimulus drives each host access as a one-cycle strobe with the other strobe low. It pulses each side-band input on its own, except in the one deliberate case where a flag is raised in the same cycle as a read of C.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;
  localparam int IDX_W  = 7;
  localparam int DATA_W = 8;

  localparam logic [IDX_W-1:0] IDX_A = 7'd10;
  localparam logic [IDX_W-1:0] IDX_B = 7'd11;
  localparam logic [IDX_W-1:0] IDX_C = 7'd12;
  localparam logic [IDX_W-1:0] IDX_D = 7'd13;

  localparam logic [DATA_W-1:0] A_RST = 8'h26;
  localparam logic [DATA_W-1:0] B_RST = 8'h02;
  localparam logic [DATA_W-1:0] D_VAL = 8'h80;

  localparam int FREEZE_BIT = 7;
  localparam int UIE_BIT    = 4;
  localparam int UIP_BIT    = 7;
  localparam int NFLAG      = 3;

  function automatic logic is_time_idx(input logic [IDX_W-1:0] i);
    return (i == 7'd0) || (i == 7'd2) || (i == 7'd4) ||
           (i >= 7'd6 && i <= 7'd9);
  endfunction
endpackage

// File: rtl/rtc_index_reg.sv
module rtc_index_reg
  import rtc_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [IDX_W-1:0]  idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   idx_o <= '0;
    else if (ld_i) idx_o <= wdata_i[IDX_W-1:0];
  end

  p_idx_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> idx_o == $past(wdata_i[IDX_W-1:0]));
endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store
  import rtc_port_pkg::*;
#(
  parameter int DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              uip_set_i,
  input  logic              uip_clr_i,
  input  logic [NFLAG-1:0]  flag_set_i,
  output logic [DATA_W-1:0] reg_a_o,
  output logic [DATA_W-1:0] reg_b_o,
  output logic [DATA_W-1:0] reg_c_o,
  output logic              irq_o,
  output logic              time_reload_o
);
  logic [DATA_W-1:0] a_q, b_q, a_d, b_d;
  logic [NFLAG-1:0]  flag_q, flag_d;
  logic is_a, is_b, is_c, is_d, freeze_wr;

  assign is_a = idx_i == IDX_A;
  assign is_b = idx_i == IDX_B;
  assign is_c = idx_i == IDX_C;
  assign is_d = idx_i == IDX_D;
  assign freeze_wr = wr_en_i && is_b && wdata_i[FREEZE_BIT];

  always_comb begin
    a_d = a_q;
    if (wr_en_i && is_a) a_d[UIP_BIT-1:0] = wdata_i[UIP_BIT-1:0];
    if (freeze_wr || uip_clr_i)           a_d[UIP_BIT] = 1'b0;
    else if (uip_set_i && !b_q[FREEZE_BIT]) a_d[UIP_BIT] = 1'b1;

    b_d = b_q;
    if (wr_en_i && is_b) begin
      b_d = wdata_i;
      if (wdata_i[FREEZE_BIT]) b_d[UIE_BIT] = 1'b0;
    end

    // clear-on-read first, so a flag raised in the same cycle survives
    flag_d = ((rd_en_i && is_c) ? '0 : flag_q) | flag_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= A_RST;
      b_q    <= B_RST;
      flag_q <= '0;
    end else begin
      a_q    <= a_d;
      b_q    <= b_d;
      flag_q <= flag_d;
    end
  end

  assign reg_a_o = a_q;
  assign reg_b_o = b_q;
  assign reg_c_o = {|flag_q, flag_q, {(DATA_W-1-NFLAG){1'b0}}};
  assign irq_o   = |flag_q;
  assign time_reload_o = wr_en_i &&
    ((is_time_idx(idx_i) && !b_q[FREEZE_BIT]) ||
     (is_b && b_q[FREEZE_BIT] && !wdata_i[FREEZE_BIT]));

  p_uip_ro_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && is_a && !uip_set_i && !uip_clr_i) |=> a_q[UIP_BIT] == $past(a_q[UIP_BIT]));
  p_freeze_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_wr |=> (!b_q[UIE_BIT] && b_q[FREEZE_BIT] && !a_q[UIP_BIT]));
  p_ro_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (is_c || is_d) && !rd_en_i && flag_set_i == '0) |=> $stable(flag_q));
  p_clear_on_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && is_c && flag_set_i == '0) |=> !irq_o);
  p_flag_kept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flag_set_i) |=> irq_o);
  p_uip_frozen_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_q[FREEZE_BIT] && !a_q[UIP_BIT] && !(wr_en_i && is_b)) |=> !a_q[UIP_BIT]);
endmodule

// File: rtl/rtc_index_port.sv
module rtc_index_port
  import rtc_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o,
  input  logic              uip_set_i,
  input  logic              uip_clr_i,
  input  logic [2:0]        flag_set_i,
  output logic [7:0]        ctrl_a_o,
  output logic [7:0]        ctrl_b_o,
  output logic              time_reload_o
);
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] store_rd, reg_c;
  logic data_wr, data_rd, is_ctrl;

  assign data_wr = wr_i && addr_i;
  assign data_rd = rd_i && addr_i;
  assign is_ctrl = idx >= IDX_A && idx <= IDX_D;

  rtc_index_reg u_idx (
    .clk_i, .rst_ni,
    .ld_i    (wr_i && !addr_i),
    .wdata_i (wdata_i),
    .idx_o   (idx)
  );

  rtc_byte_store u_store (
    .clk_i,
    .we_i    (data_wr && !is_ctrl),
    .idx_i   (idx),
    .wdata_i (wdata_i),
    .rdata_o (store_rd)
  );

  rtc_ctrl_regs u_ctrl (
    .clk_i, .rst_ni,
    .wr_en_i       (data_wr),
    .rd_en_i       (data_rd),
    .idx_i         (idx),
    .wdata_i       (wdata_i),
    .uip_set_i, .uip_clr_i, .flag_set_i,
    .reg_a_o       (ctrl_a_o),
    .reg_b_o       (ctrl_b_o),
    .reg_c_o       (reg_c),
    .irq_o         (irq_o),
    .time_reload_o (time_reload_o)
  );

  always_comb begin
    if (!addr_i) rdata_o = 8'hFF;
    else unique case (idx)
      IDX_A:   rdata_o = ctrl_a_o;
      IDX_B:   rdata_o = ctrl_b_o;
      IDX_C:   rdata_o = reg_c;
      IDX_D:   rdata_o = D_VAL;
      default: rdata_o = store_rd;
    endcase
  end

  p_even_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !addr_i) |-> rdata_o == 8'hFF);
  p_irq_flags_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i && idx == IDX_C) |-> rdata_o[7] == irq_o);
endmodule

// File: tb/rtc_index_port_tb.sv
module rtc_index_port_tb;
  logic clk = 0, rst_n = 0;
  logic addr = 0, wr = 0, rd = 0, uset = 0, uclr = 0;
  logic [7:0] wdata = 0;
  logic [2:0] fset = 0;
  logic [7:0] rdata, ca, cb;
  logic irq, reload;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  rtc_index_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .irq_o(irq),
    .uip_set_i(uset), .uip_clr_i(uclr), .flag_set_i(fset),
    .ctrl_a_o(ca), .ctrl_b_o(cb), .time_reload_o(reload));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare read data against the scoreboard
  always @(negedge clk) if (rd && !done) begin
    if (exp_q.size() == 0) check("scoreboard-empty", 8'h00, 8'h01);
    else check(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  task automatic acc_wr(input logic a, input logic [7:0] d, output logic rl);
    addr = a; wdata = d; wr = 1;
    @(negedge clk) rl = reload;
    @(posedge clk); #1 wr = 0;
  endtask

  task automatic acc_rd(input logic a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr = a; rd = 1;
    @(posedge clk); #1 rd = 0;
  endtask

  task automatic wreg(input logic [6:0] i, input logic [7:0] d, output logic rl);
    logic x;
    acc_wr(0, {1'b0, i}, x);
    acc_wr(1, d, rl);
  endtask

  task automatic rreg(input logic [6:0] i, input logic [7:0] exp, input string tag);
    logic x;
    acc_wr(0, {1'b0, i}, x);
    acc_rd(1, exp, tag);
  endtask

  task automatic pulse_uip(input logic s);
    if (s) uset = 1; else uclr = 1;
    @(posedge clk); #1 uset = 0; uclr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic rl, x;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    // R7 reset values
    check("R7 irq", {7'b0, irq}, 8'h00);
    rreg(10, 8'h26, "R7 A");
    rreg(11, 8'h02, "R7 B");
    rreg(12, 8'h00, "R7 C");
    rreg(13, 8'h80, "R7 D");
    // R2 even read
    acc_rd(0, 8'hFF, "R2 even");
    // R1 index bit 7 dropped -> index 11
    acc_wr(0, 8'h8B, x);
    acc_rd(1, 8'h02, "R1 idx");
    // R3 UIP read-only
    wreg(10, 8'hFF, x); rreg(10, 8'h7F, "R3 A lo");
    pulse_uip(1);       rreg(10, 8'hFF, "R12 uip set");
    wreg(10, 8'h00, x); rreg(10, 8'h80, "R3 A keep");
    pulse_uip(0);       rreg(10, 8'h00, "R12 uip clr");
    wreg(10, 8'h26, x);
    // R12 freeze blocks uip set
    wreg(11, 8'h82, x);
    pulse_uip(1);       rreg(10, 8'h26, "R12 frozen");
    wreg(11, 8'h02, rl); check("R9 unfreeze", {7'b0, rl}, 8'h01);
    // R4 freeze write masks bit 4, clears UIP
    pulse_uip(1);       rreg(10, 8'hA6, "R4 pre");
    wreg(11, 8'h92, x);
    rreg(11, 8'h82, "R4 B");
    rreg(10, 8'h26, "R4 A");
    // R9 reload strobe
    wreg(0, 8'h15, rl);  check("R9 frozen time", {7'b0, rl}, 8'h00);
    wreg(11, 8'h12, rl); check("R9 clear freeze", {7'b0, rl}, 8'h01);
    wreg(11, 8'h02, rl); check("R9 already clear", {7'b0, rl}, 8'h00);
    wreg(4, 8'h09, rl);  check("R9 time hr", {7'b0, rl}, 8'h01);
    wreg(9, 8'h24, rl);  check("R9 time yr", {7'b0, rl}, 8'h01);
    wreg(1, 8'hC3, rl);  check("R9 alarm", {7'b0, rl}, 8'h00);
    // R8 storage
    rreg(1, 8'hC3, "R8 alarm");
    wreg(64, 8'h5A, x);  rreg(64, 8'h5A, "R8 mid");
    wreg(127, 8'hA5, x); rreg(127, 8'hA5, "R8 top");
    rreg(4, 8'h09, "R8 time");
    // R5 C and D ignore writes
    wreg(12, 8'hFF, x); check("R5 irq", {7'b0, irq}, 8'h00);
    rreg(12, 8'h00, "R5 C");
    wreg(13, 8'h00, x); rreg(13, 8'h80, "R5 D");
    // R11 / R6
    fset = 3'b100; @(posedge clk); #1 fset = 0;
    check("R11 irq up", {7'b0, irq}, 8'h01);
    rreg(12, 8'hC0, "R6 C read");
    check("R6 irq down", {7'b0, irq}, 8'h00);
    acc_rd(1, 8'h00, "R6 C cleared");
    // R10 flag in same cycle as read
    fset = 3'b010; @(posedge clk); #1 fset = 0;
    exp_q.push_back(8'hA0); tag_q.push_back("R10 read");
    addr = 1; rd = 1; fset = 3'b100;
    @(posedge clk); #1 rd = 0; fset = 0;
    check("R10 irq kept", {7'b0, irq}, 8'h01);
    acc_rd(1, 8'hC0, "R10 new flag");
    fset = 3'b001; @(posedge clk); #1 fset = 0;
    acc_rd(1, 8'h90, "R11 upd flag");
    check("R11 irq low", {7'b0, irq}, 8'h00);
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule